// File: doc/BRIEF.md
# APB Register Read Port with a Wait-Stated Queue Read

This block is an APB subordinate that answers reads from four word-addressed sources. Three are plain registers: a status word carrying the queue flags, a saturating event counter, and a fixed identification word. Their values reach PRDATA through a combinational decode of PADDR, and these reads finish on the first ACCESS cycle. The fourth address is the read port of a small internal queue. A read there removes the oldest entry, so the block holds PREADY low for one ACCESS cycle before it completes. The handshake has the same form for every read. Only its length changes.

A separate push port fills the queue, so a test or a neighbouring block can load it. The block has no other write path. A write access completes at once and changes nothing. PRDATA is held at zero outside read accesses and for addresses that are not mapped. The manager therefore never captures an undefined value.

Top module: `apb_regread_sub`

## Requirements
- R1: With the default address parameters, a read of byte address 0x00 returns the status word, with bit 0 set when the queue is empty, bit 1 set when it is full, and every other bit zero. Address 0x04 returns the event counter, zero-extended. Address 0x08 returns the constant ID_VALUE.
- R2: A read of any address other than 0x00, 0x04, 0x08 or 0x0C returns zero.
- R3: PRDATA is zero whenever PSEL is low or PWRITE is high.
- R4: Every access other than a read of 0x0C has PREADY high on its first ACCESS cycle. This includes all writes, and such accesses complete with no wait state.
- R5: A read of 0x0C has PREADY low on its first ACCESS cycle and high on its second. At completion PRDATA holds the oldest queue entry.
- R6: The queue loses exactly one entry per completed read of 0x0C, and only on the completion cycle. Successive reads return the entries in the order they were pushed.
- R7: A read of 0x0C while the queue is empty takes the same single wait state, returns zero and leaves the queue empty.
- R8: The counter adds one on each clock edge at which event_in is high and stays at 2^CNT_W-1 once it gets there.
- R9: A push while the queue holds DEPTH entries is ignored. The full flag is set at exactly DEPTH entries.
- R10: After reset the counter is zero and the queue is empty, so the status reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB enable (ACCESS phase) |
| pwrite | input | 1 | APB direction, high for a write |
| paddr | input | AW | APB byte address |
| prdata | output | DW | APB read data |
| pready | output | 1 | APB ready |
| event_in | input | 1 | Event pulse for the counter |
| push_valid | input | 1 | Push one entry into the queue |
| push_data | input | DW | Entry to push |

## Verification
The hardest case to reach from the ports is counter saturation. The counter has to be driven through its whole 16-bit range and then read, and the read has to show that further events leave it at the top value. The bench holds event_in high for more than 65,535 edges, reads the counter, sends more events and reads it again. The queue edges need a set sequence: a read from the empty queue, a push past full, four draining reads, then one more empty read. A scoreboard checks both the returned data and the counted wait states on every read.

// File: rtl/apb_regread_sub.sv
module apb_regread_sub #(
  parameter int AW = 8,
  parameter int DW = 32,
  parameter int CNT_W = 16,
  parameter int DEPTH = 4,
  parameter logic [DW-1:0] ID_VALUE = 32'hA5B0_0C17,
  parameter logic [AW-1:0] ADDR_STAT = 8'h00,
  parameter logic [AW-1:0] ADDR_CNT = 8'h04,
  parameter logic [AW-1:0] ADDR_ID = 8'h08,
  parameter logic [AW-1:0] ADDR_FIFO = 8'h0C
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          psel,
  input  logic          penable,
  input  logic          pwrite,
  input  logic [AW-1:0] paddr,
  output logic [DW-1:0] prdata,
  output logic          pready,
  input  logic          event_in,
  input  logic          push_valid,
  input  logic [DW-1:0] push_data
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PW:0] FULL_N = (PW+1)'(DEPTH);

  logic [DW-1:0]    mem [DEPTH];
  logic [PW-1:0]    wr_ptr, rd_ptr;
  logic [PW:0]      fcnt_q;
  logic [CNT_W-1:0] cnt_q;
  logic             held_q;

  wire empty = (fcnt_q == '0);
  wire full = (fcnt_q == FULL_N);
  wire push_ok = push_valid & ~full;
  wire q_access = psel & penable & ~pwrite & (paddr == ADDR_FIFO);
  wire pop = q_access & held_q & ~empty;

  assign pready = ~q_access | held_q;

  always_ff @(posedge clk) begin
    if (!rst_n) held_q <= 1'b0;
    else held_q <= q_access & ~held_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else if (event_in && cnt_q != '1) cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fcnt_q <= '0;
    end else begin
      if (push_ok) wr_ptr <= (wr_ptr == PW'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
      if (pop) rd_ptr <= (rd_ptr == PW'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
      case ({push_ok, pop})
        2'b10: fcnt_q <= fcnt_q + 1'b1;
        2'b01: fcnt_q <= fcnt_q - 1'b1;
        default: ;
      endcase
    end
  end

  always_comb begin
    prdata = '0;
    if (psel && !pwrite) begin
      case (paddr)
        ADDR_STAT: prdata = {{(DW-2){1'b0}}, full, empty};
        ADDR_CNT:  prdata = {{(DW-CNT_W){1'b0}}, cnt_q};
        ADDR_ID:   prdata = ID_VALUE;
        ADDR_FIFO: prdata = empty ? '0 : mem[rd_ptr];
        default:   prdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/apb_regread_chk.sv
module apb_regread_chk #(
  parameter int AW = 8,
  parameter int DW = 32,
  parameter int CNT_W = 16,
  parameter int FW = 3,
  parameter int DEPTH = 4,
  parameter logic [AW-1:0] ADDR_FIFO = 8'h0C
) (
  input logic          clk,
  input logic          rst_n,
  input logic          psel,
  input logic          penable,
  input logic          pwrite,
  input logic [AW-1:0] paddr,
  input logic [DW-1:0] prdata,
  input logic          pready,
  input logic          push_valid,
  input logic [CNT_W-1:0] cnt_q,
  input logic [FW-1:0] fcnt
);
  wire q_rd = psel && penable && !pwrite && (paddr == ADDR_FIFO);

  p_idle_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!psel || pwrite) |-> prdata == '0);

  p_plain_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && penable && !q_rd) |-> pready);

  p_first_wait_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (q_rd && !$past(penable)) |-> !pready);

  p_one_wait_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && penable && !pready) |=> (!(psel && penable) || pready));

  p_pop_at_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!push_valid && !(q_rd && pready)) |=> fcnt == $past(fcnt));

  p_empty_stays_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fcnt == '0 && !push_valid) |=> fcnt == '0);

  p_saturate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '1) |=> cnt_q == '1);

  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fcnt <= FW'(DEPTH));
endmodule

bind apb_regread_sub apb_regread_chk #(
  .AW(AW), .DW(DW), .CNT_W(CNT_W), .FW(PW+1), .DEPTH(DEPTH), .ADDR_FIFO(ADDR_FIFO)
) u_chk (
  .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
  .paddr(paddr), .prdata(prdata), .pready(pready), .push_valid(push_valid),
  .cnt_q(cnt_q), .fcnt(fcnt_q)
);

// File: tb/tb_apb_regread_sub.sv
`timescale 1ns/1ps
module tb_apb_regread_sub;
  localparam logic [31:0] ID = 32'hA5B0_0C17;
  logic clk = 0, rst_n = 0;
  logic psel = 0, penable = 0, pwrite = 0, event_in = 0, push_valid = 0;
  logic [7:0] paddr = 0;
  logic [31:0] push_data = 0;
  logic [31:0] prdata;
  logic pready;
  int checks = 0, errors = 0, waitcnt = 0;
  bit done = 0;
  logic [31:0] q_data[$];
  int q_waits[$];
  string q_tag[$];

  always #2 clk = ~clk;

  apb_regread_sub dut (.clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .prdata(prdata), .pready(pready),
    .event_in(event_in), .push_valid(push_valid), .push_data(push_data));

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && psel && penable) begin
      if (!pready) waitcnt++;
      else begin
        if (!pwrite) begin
          if (q_data.size() == 0) chk("R5 unexpected read completion", 1, 0);
          else begin
            string t;
            int w;
            logic [31:0] d;
            t = q_tag.pop_front();
            d = q_data.pop_front();
            w = q_waits.pop_front();
            chk({t, " data"}, prdata, d);
            chk({t, " wait states"}, waitcnt, w);
          end
        end
        waitcnt = 0;
      end
    end
  end

  task automatic rd(logic [7:0] a, logic [31:0] d, int w, string tag);
    q_data.push_back(d); q_waits.push_back(w); q_tag.push_back(tag);
    @(posedge clk) #1; psel = 1; penable = 0; pwrite = 0; paddr = a;
    @(posedge clk) #1; penable = 1;
    forever begin @(negedge clk); if (pready) break; end
    @(posedge clk) #1; psel = 0; penable = 0;
  endtask

  task automatic wr(logic [7:0] a);
    @(posedge clk) #1; psel = 1; penable = 0; pwrite = 1; paddr = a;
    @(posedge clk) #1; penable = 1;
    @(negedge clk);
    chk("R4 write ready on first access", pready, 1);
    chk("R3 prdata zero on write", prdata, 0);
    @(posedge clk) #1; psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic push(logic [31:0] d);
    @(posedge clk) #1; push_valid = 1; push_data = d;
    @(posedge clk) #1; push_valid = 0;
  endtask

  task automatic events(int n);
    @(posedge clk) #1; event_in = 1;
    repeat (n) @(posedge clk);
    #1 event_in = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk("R10 idle prdata after reset", prdata, 0);
    rd(8'h00, 32'h1, 0, "R10 R1 status empty after reset");
    rd(8'h04, 32'h0, 0, "R10 counter zero after reset");
    rd(8'h08, ID, 0, "R1 id word");
    rd(8'h10, 32'h0, 0, "R2 unmapped 0x10");
    rd(8'hFC, 32'h0, 0, "R2 unmapped 0xFC");
    wr(8'h08);
    @(posedge clk) #1; paddr = 8'h08;
    @(negedge clk);
    chk("R3 prdata zero with psel low", prdata, 0);
    rd(8'h0C, 32'h0, 1, "R7 empty queue read");
    rd(8'h00, 32'h1, 0, "R7 queue still empty");
    push(32'h11); push(32'h22); push(32'h33); push(32'h44); push(32'h55);
    rd(8'h00, 32'h2, 0, "R9 R1 status full");
    rd(8'h0C, 32'h11, 1, "R5 R6 first entry");
    rd(8'h00, 32'h0, 0, "R6 one pop leaves not full");
    rd(8'h0C, 32'h22, 1, "R6 second entry");
    rd(8'h0C, 32'h33, 1, "R6 third entry");
    rd(8'h0C, 32'h44, 1, "R9 last entry, overflow push dropped");
    rd(8'h0C, 32'h0, 1, "R7 drained queue read");
    rd(8'h00, 32'h1, 0, "R6 empty after drain");
    push(32'hDEAD_0007);
    rd(8'h0C, 32'hDEAD_0007, 1, "R5 single entry after refill");
    events(3);
    @(posedge clk);
    events(2);
    rd(8'h04, 32'd5, 0, "R8 counter after five events");
    events(65540);
    rd(8'h04, 32'hFFFF, 0, "R8 counter saturated");
    events(7);
    rd(8'h04, 32'hFFFF, 0, "R8 counter stays saturated");
    repeat (3) @(posedge clk);
    chk("R5 scoreboard drained", q_data.size(), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule